// File: doc/BRIEF.md
# Eight-bit Accumulator Arithmetic and Logic Unit

This block is the purely combinational datapath for an eight-bit accumulator machine. Each evaluation takes the accumulator byte, a second operand byte, the stored carry and overflow flags, the decimal-mode flag and a four-bit operation code. It returns a result byte, a flag that says whether that byte should be written back to the accumulator, and new negative, overflow, zero and carry flags. Flag storage, decoding and timing belong to the surrounding machine.

Add and subtract both chain through the carry flag, so multi-byte arithmetic is done one byte at a time starting from the lowest byte. For subtraction the carry acts as an inverted borrow: a set carry means no borrow is pending. When the decimal flag is set, add and subtract treat each byte as two packed BCD digits. All other operations ignore that flag. The shift and rotate group moves bits through the carry. The logic group combines the two bytes. A bit-test operation only updates flags.

Top module: `acc_alu8`

## Requirements
- R1: Add (op 0) gives result = low 8 bits of acc + operand + carry_i. C is set when that sum is above 255.
- R2: Subtract (op 1) gives result = low 8 bits of acc − operand − (1 − carry_i). C is 0 when that difference is below zero and 1 otherwise.
- R3: For add and subtract, in both modes, V is set when the same computation done on the signed (two's complement) inputs falls outside −128..+127.
- R4: Shift right (op 2) puts 0 in bit 7 and moves bit 0 to C. Shift left (op 3) puts 0 in bit 0 and moves bit 7 to C.
- R5: Rotate right (op 4) puts carry_i in bit 7 and moves bit 0 to C. Rotate left (op 5) puts carry_i in bit 0 and moves bit 7 to C.
- R6: AND (op 6), OR (op 7) and XOR (op 8) give the bitwise result, and C and V keep their input values.
- R7: Bit-test (op 9) sets Z when acc AND operand is zero, copies operand bit 7 to N and bit 6 to V, and keeps C. It drives result_valid low and result equal to acc.
- R8: Decimal add (op 0 with the decimal flag set, each nibble a digit 0–9, high nibble the tens) gives the BCD sum modulo 100 of both operands plus carry_i. C is set when that sum reaches 100.
- R9: Decimal subtract (op 1 with the decimal flag set) gives the BCD value of acc − operand − (1 − carry_i), plus 100 if negative. C is 0 exactly when the difference is negative.
- R10: The decimal flag has no effect on ops 2 through 9.
- R11: For every op that drives result_valid high, Z is set when the result is zero and N equals result bit 7. Shifts and rotates keep V.
- R12: result_valid is high for ops 0–8. Unused codes 10–15 drive it low, pass acc to result, keep C and V, and take N and Z from acc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand byte |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| decimal_i | input | 1 | Packed-BCD mode select for add and subtract |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Result byte |
| result_valid_o | output | 1 | High when result_o should be written to the accumulator |
| neg_o | output | 1 | New N flag |
| ovf_o | output | 1 | New V flag |
| zero_o | output | 1 | New Z flag |
| carry_o | output | 1 | New C flag |

## Verification
The digit-range assertion for decimal arithmetic assumes that every nibble of both operands is a legal digit 0–9. It is guarded on that condition, because out-of-range digits have no defined decimal meaning. The directed stimulus follows the same rule: in decimal mode it applies only digit pairs built from 0–99, while binary and non-arithmetic operations get full-range bytes. The other assertions only relate flags to inputs and outputs, so they place no limit on the operands.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SHR  = 4'd2,
    OP_SHL  = 4'd3,
    OP_RTR  = 4'd4,
    OP_RTL  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_TEST = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/acc_alu8_arith.sv
module acc_alu8_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             dec_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             vout_o
);
  localparam int NIB = WIDTH / 4;
  localparam int MSB = WIDTH - 1;

  // Digit-serial BCD add: a digit above 9 is corrected by +6 and carries.
  function automatic logic [WIDTH:0] bcd_add(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic c);
    logic [4:0]       s;
    logic [WIDTH-1:0] r;
    logic             k;
    k = c;
    r = '0;
    for (int i = 0; i < NIB; i++) begin
      s = {1'b0, x[4*i +: 4]} + {1'b0, y[4*i +: 4]} + {4'b0, k};
      if (s > 5'd9) begin
        s = s + 5'd6;
        k = 1'b1;
      end else begin
        k = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    return {k, r};
  endfunction

  // Digit-serial BCD subtract: a digit that borrows is corrected by -6.
  function automatic logic [WIDTH:0] bcd_sub(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic c);
    logic [4:0]       s;
    logic [WIDTH-1:0] r;
    logic             bw;
    bw = ~c;
    r  = '0;
    for (int i = 0; i < NIB; i++) begin
      s = {1'b0, x[4*i +: 4]} - {1'b0, y[4*i +: 4]} - {4'b0, bw};
      if (s[4]) begin
        s  = s - 5'd6;
        bw = 1'b1;
      end else begin
        bw = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    return {~bw, r};
  endfunction

  function automatic logic [WIDTH:0] bin_addsub(input logic [WIDTH-1:0] x,
                                                input logic [WIDTH-1:0] y,
                                                input logic c,
                                                input logic sub);
    logic [WIDTH-1:0] yy;
    yy = sub ? ~y : y;
    return {1'b0, x} + {1'b0, yy} + {{WIDTH{1'b0}}, c};
  endfunction

  logic [WIDTH:0]   bin_sum;
  logic [WIDTH:0]   dec_sum;
  logic [WIDTH-1:0] eff_b;

  assign eff_b   = sub_i ? ~b_i : b_i;
  assign bin_sum = bin_addsub(a_i, b_i, cin_i, sub_i);
  assign dec_sum = sub_i ? bcd_sub(a_i, b_i, cin_i) : bcd_add(a_i, b_i, cin_i);

  // Signed overflow is judged on the binary form in both modes.
  assign vout_o = (a_i[MSB] == eff_b[MSB]) && (bin_sum[MSB] != a_i[MSB]);
  assign res_o  = dec_i ? dec_sum[WIDTH-1:0] : bin_sum[WIDTH-1:0];
  assign cout_o = dec_i ? dec_sum[WIDTH] : bin_sum[WIDTH];

endmodule

// File: rtl/acc_alu8_shift.sv
module acc_alu8_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  input  logic             right_i,
  input  logic             rotate_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  logic fill;
  assign fill = rotate_i ? cin_i : 1'b0;

  always_comb begin
    if (right_i) begin
      res_o  = {fill, a_i[MSB:1]};
      cout_o = a_i[0];
    end else begin
      res_o  = {a_i[MSB-1:0], fill};
      cout_o = a_i[MSB];
    end
  end

endmodule

// File: rtl/acc_alu8_logic.sv
module acc_alu8_logic
  import acc_alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    case (sel_i)
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic             decimal_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_valid_o,
  output logic             neg_o,
  output logic             ovf_o,
  output logic             zero_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  // Named decode events, visible to the bound checker.
  logic is_arith, is_shift, is_logic, is_test;
  logic [1:0] lg_sel;

  logic [WIDTH-1:0] arith_res, shift_res, logic_res;
  logic             arith_c, arith_v, shift_c;

  always_comb begin
    is_arith = 1'b0;
    is_shift = 1'b0;
    is_logic = 1'b0;
    is_test  = 1'b0;
    lg_sel   = LG_AND;
    case (op_i)
      OP_ADD, OP_SUB:                 is_arith = 1'b1;
      OP_SHR, OP_SHL, OP_RTR, OP_RTL: is_shift = 1'b1;
      OP_AND:  is_logic = 1'b1;
      OP_OR:   begin is_logic = 1'b1; lg_sel = LG_OR;  end
      OP_XOR:  begin is_logic = 1'b1; lg_sel = LG_XOR; end
      OP_TEST: is_test = 1'b1;
      default: ;
    endcase
  end

  acc_alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .cin_i  (carry_i),
    .dec_i  (decimal_i),
    .sub_i  (op_i == OP_SUB),
    .res_o  (arith_res),
    .cout_o (arith_c),
    .vout_o (arith_v)
  );

  acc_alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i      (acc_i),
    .cin_i    (carry_i),
    .right_i  ((op_i == OP_SHR) || (op_i == OP_RTR)),
    .rotate_i ((op_i == OP_RTR) || (op_i == OP_RTL)),
    .res_o    (shift_res),
    .cout_o   (shift_c)
  );

  acc_alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (lg_sel),
    .res_o (logic_res)
  );

  always_comb begin
    result_o       = acc_i;
    result_valid_o = 1'b0;
    carry_o        = carry_i;
    ovf_o          = ovf_i;
    if (is_arith) begin
      result_o       = arith_res;
      result_valid_o = 1'b1;
      carry_o        = arith_c;
      ovf_o          = arith_v;
    end else if (is_shift) begin
      result_o       = shift_res;
      result_valid_o = 1'b1;
      carry_o        = shift_c;
    end else if (is_logic) begin
      result_o       = logic_res;
      result_valid_o = 1'b1;
    end
    if (is_test) begin
      neg_o  = opnd_i[MSB];
      ovf_o  = opnd_i[MSB-1];
      zero_o = ~|(acc_i & opnd_i);
    end else begin
      neg_o  = result_o[MSB];
      zero_o = ~|result_o;
    end
  end

endmodule

// File: rtl/acc_alu8_checker.sv
module acc_alu8_checker
  import acc_alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] acc_i,
  input logic [WIDTH-1:0] opnd_i,
  input logic             carry_i,
  input logic             ovf_i,
  input logic             decimal_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             result_valid_o,
  input logic             neg_o,
  input logic             ovf_o,
  input logic             zero_o,
  input logic             carry_o
);
  localparam int MSB = WIDTH - 1;
  localparam int NIB = WIDTH / 4;

  function automatic logic digits_ok(input logic [WIDTH-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NIB; i++) ok = ok && (x[4*i +: 4] <= 4'd9);
    return ok;
  endfunction

  logic [WIDTH:0] plain_sum;
  assign plain_sum = {1'b0, acc_i} + {1'b0, opnd_i} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    if (op_i == OP_ADD && !decimal_i)
      assert_add_sum_R1: assert ({carry_o, result_o} == plain_sum);
    if (op_i == OP_SHR)
      assert_shr_fill_R4: assert (!result_o[MSB] && carry_o == acc_i[0]);
    if (op_i == OP_RTL)
      assert_rtl_carry_R5: assert (result_o[0] == carry_i && carry_o == acc_i[MSB]);
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
      assert_logic_keeps_cv_R6: assert (carry_o == carry_i && ovf_o == ovf_i);
    if (op_i == OP_TEST)
      assert_test_flags_R7: assert (!result_valid_o && neg_o == opnd_i[MSB]
                                    && ovf_o == opnd_i[MSB-1] && carry_o == carry_i);
    if ((op_i == OP_ADD || op_i == OP_SUB) && decimal_i
        && digits_ok(acc_i) && digits_ok(opnd_i))
      assert_bcd_digits_R8: assert (digits_ok(result_o));
    if (result_valid_o)
      assert_nz_from_result_R11: assert (zero_o == (result_o == '0) && neg_o == result_o[MSB]);
    if (op_i >= 4'd10)
      assert_unused_no_write_R12: assert (!result_valid_o && result_o == acc_i);
  end
endmodule

bind acc_alu8 acc_alu8_checker #(.WIDTH(WIDTH)) u_acc_alu8_checker (
  .acc_i          (acc_i),
  .opnd_i         (opnd_i),
  .carry_i        (carry_i),
  .ovf_i          (ovf_i),
  .decimal_i      (decimal_i),
  .op_i           (op_i),
  .result_o       (result_o),
  .result_valid_o (result_valid_o),
  .neg_o          (neg_o),
  .ovf_o          (ovf_o),
  .zero_o         (zero_o),
  .carry_o        (carry_o)
);

// File: tb/acc_alu8_bench.sv
module acc_alu8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc, opnd;
  logic       cin, vin, dec;
  logic [3:0] op;
  logic [7:0] res;
  logic       valid, n_f, v_f, z_f, c_f;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  acc_alu8 u_acc_alu8 (
    .acc_i(acc), .opnd_i(opnd), .carry_i(cin), .ovf_i(vin), .decimal_i(dec),
    .op_i(op), .result_o(res), .result_valid_o(valid), .neg_o(n_f),
    .ovf_o(v_f), .zero_o(z_f), .carry_o(c_f)
  );

  function automatic int to_dec(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic logic [7:0] from_dec(input int x);
    logic [3:0] hi, lo;
    hi = 4'(x / 10);
    lo = 4'(x % 10);
    return {hi, lo};
  endfunction

  // Model output packing: {valid, n, v, z, c, result[7:0]}
  function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic c,
                                        input logic v, input logic d);
    int t, sv;
    logic [7:0] r;
    logic wv, nn, vv, zz, cc;
    r = a; wv = 1'b0; cc = c; vv = v;
    case (o)
      4'd0: begin
        sv = int'($signed(a)) + int'($signed(b)) + int'(c);
        vv = (sv > 127) || (sv < -128);
        wv = 1'b1;
        if (d) begin
          t = to_dec(a) + to_dec(b) + int'(c);
          cc = (t >= 100); r = from_dec(t % 100);
        end else begin
          t = int'(a) + int'(b) + int'(c);
          cc = (t > 255); r = 8'(t);
        end
      end
      4'd1: begin
        sv = int'($signed(a)) - int'($signed(b)) - (1 - int'(c));
        vv = (sv > 127) || (sv < -128);
        wv = 1'b1;
        if (d) begin
          t = to_dec(a) - to_dec(b) - (1 - int'(c));
          cc = (t >= 0); if (t < 0) t = t + 100;
          r = from_dec(t);
        end else begin
          t = int'(a) - int'(b) - (1 - int'(c));
          cc = (t >= 0); r = 8'(t);
        end
      end
      4'd2: begin r = a >> 1;        cc = a[0]; wv = 1'b1; end
      4'd3: begin r = a << 1;        cc = a[7]; wv = 1'b1; end
      4'd4: begin r = {c, a[7:1]};   cc = a[0]; wv = 1'b1; end
      4'd5: begin r = {a[6:0], c};   cc = a[7]; wv = 1'b1; end
      4'd6: begin r = a & b; wv = 1'b1; end
      4'd7: begin r = a | b; wv = 1'b1; end
      4'd8: begin r = a ^ b; wv = 1'b1; end
      default: ;
    endcase
    if (o == 4'd9) begin
      nn = b[7]; vv = b[6]; zz = ((a & b) == 8'h00);
    end else begin
      nn = r[7]; zz = (r == 8'h00);
    end
    return {wv, nn, vv, zz, cc, r};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic v, input logic d, input string tag);
    logic [12:0] exp, act;
    @(negedge clk);
    op = o; acc = a; opnd = b; cin = c; vin = v; dec = d;
    @(posedge clk);
    #1;
    exp = model(o, a, b, c, v, d);
    act = {valid, n_f, v_f, z_f, c_f, res};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b v=%b d=%b: actual {w,n,v,z,c,res}=%b_%b%b%b%b_%h expected %b_%b%b%b%b_%h",
               tag, o, a, b, c, v, d, act[12], act[11], act[10], act[9], act[8], act[7:0],
               exp[12], exp[11], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic t_reset_state;
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R1 zero sum under reset");
    rst = 1'b0;
  endtask

  task automatic t_binary_add;
    apply(4'd0, 8'hF0, 8'h20, 1'b0, 1'b0, 1'b0, "R1 low byte carry out");
    apply(4'd0, 8'h30, 8'h01, 1'b1, 1'b0, 1'b0, "R1 high byte carry in");
    apply(4'd0, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, "R1 wrap to zero");
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 13)
        for (int c = 0; c < 2; c++)
          apply(4'd0, 8'(a), 8'(b), 1'(c), 1'(b & 1), 1'b0, "R1 add sweep");
  endtask

  task automatic t_binary_sub;
    apply(4'd1, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, "R2 underflow clears carry");
    apply(4'd1, 8'h05, 8'h05, 1'b1, 1'b0, 1'b0, "R2 equal gives zero");
    apply(4'd1, 8'h05, 8'h05, 1'b0, 1'b0, 1'b0, "R2 pending borrow");
    for (int a = 0; a < 256; a += 11)
      for (int b = 0; b < 256; b += 9)
        for (int c = 0; c < 2; c++)
          apply(4'd1, 8'(a), 8'(b), 1'(c), 1'(a & 1), 1'b0, "R2 sub sweep");
  endtask

  task automatic t_overflow;
    apply(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0, "R3 positive overflow");
    apply(4'd0, 8'h80, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 negative overflow");
    apply(4'd0, 8'h50, 8'h2F, 1'b0, 1'b1, 1'b0, "R3 no overflow clears V");
    apply(4'd1, 8'h80, 8'h01, 1'b1, 1'b0, 1'b0, "R3 sub overflow");
    apply(4'd1, 8'h7F, 8'hFF, 1'b1, 1'b0, 1'b0, "R3 sub positive overflow");
    apply(4'd0, 8'h79, 8'h01, 1'b0, 1'b0, 1'b1, "R3 decimal binary-rule V");
  endtask

  task automatic t_shift_rotate;
    for (int o = 2; o <= 5; o++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          apply(4'(o), 8'(a), 8'h5A, 1'(c), 1'(a >> 3), 1'b0,
                (o < 4) ? "R4 shift, R11 V kept" : "R5 rotate, R11 V kept");
  endtask

  task automatic t_logic_ops;
    for (int o = 6; o <= 8; o++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 17)
          apply(4'(o), 8'(a), 8'(b), 1'(a), 1'(b), 1'b0, "R6 logic, R11 flags");
  endtask

  task automatic t_bit_test;
    apply(4'd9, 8'h0F, 8'hC0, 1'b1, 1'b0, 1'b0, "R7 disjoint sets Z, N V from operand");
    apply(4'd9, 8'hFF, 8'h41, 1'b0, 1'b0, 1'b0, "R7 overlap clears Z");
    apply(4'd9, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, "R7 all zero");
    for (int a = 0; a < 256; a += 3)
      apply(4'd9, 8'(a), 8'(255 - a * 2), 1'(a), 1'(a >> 1), 1'b0, "R7 sweep");
  endtask

  task automatic t_decimal_add;
    apply(4'd0, 8'h99, 8'h01, 1'b0, 1'b0, 1'b1, "R8 99+1 wraps with carry");
    apply(4'd0, 8'h45, 8'h45, 1'b1, 1'b0, 1'b1, "R8 digit carry");
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        apply(4'd0, from_dec(a), from_dec(b), 1'((a + b) & 1), 1'b0, 1'b1, "R8 decimal add");
  endtask

  task automatic t_decimal_sub;
    apply(4'd1, 8'h00, 8'h01, 1'b1, 1'b0, 1'b1, "R9 0-1 gives 99 no carry");
    apply(4'd1, 8'h10, 8'h01, 1'b1, 1'b0, 1'b1, "R9 low digit borrow");
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        apply(4'd1, from_dec(a), from_dec(b), 1'((a ^ b) & 1), 1'b1, 1'b1, "R9 decimal sub");
  endtask

  task automatic t_decimal_ignored;
    for (int o = 2; o <= 9; o++)
      for (int a = 0; a < 256; a += 19)
        apply(4'(o), 8'(a), 8'(a * 7 + 3), 1'(a), 1'(o), 1'b1, "R10 decimal flag ignored");
  endtask

  task automatic t_unused_codes;
    for (int o = 10; o < 16; o++) begin
      apply(4'(o), 8'h80, 8'hFF, 1'b1, 1'b0, 1'b0, "R12 unused code");
      apply(4'(o), 8'h00, 8'h12, 1'b0, 1'b1, 1'b1, "R12 unused code zero acc");
    end
    apply(4'd8, 8'h33, 8'h33, 1'b0, 1'b0, 1'b0, "R12 XOR writes, R11 zero");
  endtask

  initial begin
    op = 4'd0; acc = 8'h00; opnd = 8'h00; cin = 1'b0; vin = 1'b0; dec = 1'b0;
    repeat (2) @(posedge clk);
    t_reset_state();
    t_binary_add();
    t_binary_sub();
    t_overflow();
    t_shift_rotate();
    t_logic_ops();
    t_bit_test();
    t_decimal_add();
    t_decimal_sub();
    t_decimal_ignored();
    t_unused_codes();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule